// File: doc/BRIEF.md
# Per-Task Return Stack and Context Bank

This block keeps the return-address stacks, program counters and in-progress state bits for a small group of hardware tasks. Each task owns a four-entry last-in-first-out stack of return addresses, a program counter and four bits. Those bits say that a repeat loop, a delayed jump, a lock request or a halt-after-first-pass is currently under way. The operand that names the target task is separate from the operation, so any task may push onto, pop from, restart or reload the context of any other task.

A restart gives one task a fresh program counter and clears its in-progress bits. It leaves the stack alone, and it touches nothing outside this block, such as pointer registers or condition flags. A packed snapshot word shows the full context of one chosen task, and the same layout can be written back to restore that task. The layout is chosen so that a word holding only a program counter, with every other bit zero, starts a task cleanly.

Top module: `task_ctx_bank`

## Requirements
- R1: After reset every task has program counter 0, all state bits 0 and an empty stack; a pop from any task then returns 0.
- R2: A push writes `pushData` onto the stack of task `pushTask` only, and later pops from that task return values newest first.
- R3: `popData` shows the top entry of task `popTask` during the cycle in which `popValid` is high, and the entry is removed at the next clock edge; a pop from an empty stack returns 0 and the stack stays empty.
- R4: A push onto a full stack of four entries discards the oldest entry, so the following pops return the four newest values and then 0.
- R5: A restart sets the program counter of task `restartTask` to `restartPc` and clears all four of its state bits, visible after the next clock edge.
- R6: A restart leaves the stack of the restarted task and the program counters of all other tasks unchanged.
- R7: A mark ORs `markBits` into the state of task `markTask` (bit 0 repeat active, bit 1 delayed jump pending, bit 2 lock pending, bit 3 halt after first pass); when a mark and a restart hit the same task in one cycle, the restart wins and the bits end up 0.
- R8: `snapWord` shows the context of task `snapTask`: bits 15:0 program counter, bits 19:16 state, bits 22:20 stack depth, then one 16-bit field per stack entry starting at bit 23 with the top entry first; entries below the depth read 0.
- R9: A load replaces the whole context of task `loadTask` with `loadWord` in the R8 layout; a word that is zero apart from the program counter gives that counter, clear state and an empty stack.
- R10: A push and a pop in the same cycle to different tasks both take effect; a push and a pop to the same task in one cycle is a usage error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pushValid | input | 1 | Push request |
| pushTask | input | 2 | Task whose stack is pushed |
| pushData | input | 16 | Value to push |
| popValid | input | 1 | Pop request |
| popTask | input | 2 | Task whose stack is popped |
| popData | output | 16 | Top of the popped task's stack, 0 when empty |
| restartValid | input | 1 | Restart request |
| restartTask | input | 2 | Task to restart |
| restartPc | input | 16 | New program counter for the restart |
| markValid | input | 1 | State-bit set request |
| markTask | input | 2 | Task whose state bits are set |
| markBits | input | 4 | Bits ORed into the state |
| loadValid | input | 1 | Context restore request |
| loadTask | input | 2 | Task to restore |
| loadWord | input | 87 | Packed context to restore |
| snapTask | input | 2 | Task shown on snapWord |
| snapWord | output | 87 | Packed context of snapTask |
| taskPc | output | 64 | Program counters, task t at bits 16t+15:16t |
| taskState | output | 16 | State bits, task t at bits 4t+3:4t |

## Verification
The assertions check every cycle that the stack depth moves as each strobe implies: it grows by one below full, holds at full and at empty, and stays the same across a restart. They also check that a restart always produces the requested counter with cleared state, that a push strobe reaches at most one task, and that a push and a pop never target the same task. Only the bench scenarios can show the data itself. These cover the newest-first order of popped values, the loss of the oldest entry on overflow, and the isolation of one task's stack and counter from operations on another. They also cover the bit layout of the snapshot word and a restore followed by pops.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  parameter int TASKS   = 4;
  parameter int PC_W    = 16;
  parameter int DEPTH   = 4;
  parameter int STATE_W = 4;

  localparam int IDX_W   = $clog2(TASKS);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int ST_LSB  = PC_W;
  localparam int CNT_LSB = ST_LSB + STATE_W;
  localparam int ENT_LSB = CNT_LSB + CNT_W;
  localparam int SNAP_W  = ENT_LSB + DEPTH * PC_W;

  // meaning of the state bits
  localparam int ST_REPEAT = 0;
  localparam int ST_DJUMP  = 1;
  localparam int ST_LOCK   = 2;
  localparam int ST_HALT1  = 3;

  // strobes from control to one datapath lane
  typedef struct packed {
    logic load;
    logic restart;
    logic mark;
    logic push;
    logic pop;
  } laneCmd_t;
endpackage

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import ctx_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pushValid,
  input  logic [IDX_W-1:0]        pushTask,
  input  logic                    popValid,
  input  logic [IDX_W-1:0]        popTask,
  input  logic                    restartValid,
  input  logic [IDX_W-1:0]        restartTask,
  input  logic                    markValid,
  input  logic [IDX_W-1:0]        markTask,
  input  logic                    loadValid,
  input  logic [IDX_W-1:0]        loadTask,
  output laneCmd_t [TASKS-1:0]    cmd
);
  logic [TASKS-1:0] pushVec;

  for (genvar t = 0; t < TASKS; t++) begin : g_lane
    localparam logic [IDX_W-1:0] LaneId = IDX_W'(t);
    logic hitPush, hitPop, hitRst, hitMark, hitLoad;
    assign hitPush = pushValid    && (pushTask    == LaneId);
    assign hitPop  = popValid     && (popTask     == LaneId);
    assign hitRst  = restartValid && (restartTask == LaneId);
    assign hitMark = markValid    && (markTask    == LaneId);
    assign hitLoad = loadValid    && (loadTask    == LaneId);
    // a restore overrides everything; a pop overrides a clashing push
    assign cmd[t] = laneCmd_t'{
      load:    hitLoad,
      restart: hitRst && !hitLoad,
      mark:    hitMark && !hitRst && !hitLoad,
      push:    hitPush && !hitPop && !hitLoad,
      pop:     hitPop && !hitLoad
    };
    assign pushVec[t] = cmd[t].push;
  end

  // R10
  no_same_task_pushpop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(pushValid && popValid && (pushTask == popTask)));

  // R2
  single_push_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pushVec));
endmodule

// File: rtl/ctx_lane.sv
module ctx_lane
  import ctx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  laneCmd_t           cmd,
  input  logic [PC_W-1:0]    pushData,
  input  logic [PC_W-1:0]    restartPc,
  input  logic [STATE_W-1:0] markBits,
  input  logic [SNAP_W-1:0]  loadWord,
  output logic [PC_W-1:0]    pc,
  output logic [STATE_W-1:0] state,
  output logic [PC_W-1:0]    top,
  output logic [SNAP_W-1:0]  snap
);
  logic [PC_W-1:0]  ent [DEPTH];
  logic [CNT_W-1:0] depth;
  logic [CNT_W-1:0] ldDepthRaw;
  logic [CNT_W-1:0] ldDepth;

  assign ldDepthRaw = loadWord[CNT_LSB +: CNT_W];
  assign ldDepth    = (ldDepthRaw > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : ldDepthRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc    <= '0;
      state <= '0;
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else if (cmd.load) begin
      pc    <= loadWord[PC_W-1:0];
      state <= loadWord[ST_LSB +: STATE_W];
      depth <= ldDepth;
      for (int i = 0; i < DEPTH; i++)
        ent[i] <= (i < int'(ldDepth)) ? loadWord[ENT_LSB + i*PC_W +: PC_W] : '0;
    end else begin
      if (cmd.restart) begin
        pc    <= restartPc;
        state <= '0;
      end else if (cmd.mark) begin
        state <= state | markBits;
      end
      if (cmd.push) begin
        // shift down; the oldest entry falls off the bottom when full
        ent[0] <= pushData;
        for (int i = 1; i < DEPTH; i++) ent[i] <= ent[i-1];
        if (depth != CNT_W'(DEPTH)) depth <= depth + CNT_W'(1);
      end else if (cmd.pop) begin
        for (int i = 0; i < DEPTH - 1; i++) ent[i] <= ent[i+1];
        ent[DEPTH-1] <= '0;
        if (depth != '0) depth <= depth - CNT_W'(1);
      end
    end
  end

  assign top = (depth == '0) ? '0 : ent[0];

  always_comb begin
    snap = '0;
    snap[PC_W-1:0]            = pc;
    snap[ST_LSB +: STATE_W]   = state;
    snap[CNT_LSB +: CNT_W]    = depth;
    for (int i = 0; i < DEPTH; i++)
      snap[ENT_LSB + i*PC_W +: PC_W] = ent[i];
  end

  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.push && !cmd.load && depth != CNT_W'(DEPTH)) |=> depth == $past(depth) + CNT_W'(1));

  // R4
  full_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.push && !cmd.load && depth == CNT_W'(DEPTH)) |=> depth == CNT_W'(DEPTH));

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.pop && !cmd.load && depth == '0) |=> (depth == '0 && top == '0));

  // R5
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.restart && !cmd.load) |=> (pc == $past(restartPc) && state == '0));

  // R6
  restart_keeps_stack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.restart && !cmd.push && !cmd.pop && !cmd.load) |=>
      (depth == $past(depth) && top == $past(top)));
endmodule

// File: rtl/ctx_datapath.sv
module ctx_datapath
  import ctx_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  laneCmd_t [TASKS-1:0]     cmd,
  input  logic [PC_W-1:0]          pushData,
  input  logic [PC_W-1:0]          restartPc,
  input  logic [STATE_W-1:0]       markBits,
  input  logic [SNAP_W-1:0]        loadWord,
  input  logic [IDX_W-1:0]         popTask,
  input  logic [IDX_W-1:0]         snapTask,
  output logic [PC_W-1:0]          popData,
  output logic [SNAP_W-1:0]        snapWord,
  output logic [TASKS*PC_W-1:0]    taskPc,
  output logic [TASKS*STATE_W-1:0] taskState
);
  logic [PC_W-1:0]   laneTop  [TASKS];
  logic [SNAP_W-1:0] laneSnap [TASKS];

  for (genvar t = 0; t < TASKS; t++) begin : g_lane
    ctx_lane u_lane (
      .clk       (clk),
      .rstN      (rstN),
      .cmd       (cmd[t]),
      .pushData  (pushData),
      .restartPc (restartPc),
      .markBits  (markBits),
      .loadWord  (loadWord),
      .pc        (taskPc[t*PC_W +: PC_W]),
      .state     (taskState[t*STATE_W +: STATE_W]),
      .top       (laneTop[t]),
      .snap      (laneSnap[t])
    );
  end

  assign popData  = laneTop[popTask];
  assign snapWord = laneSnap[snapTask];
endmodule

// File: rtl/task_ctx_bank.sv
module task_ctx_bank
  import ctx_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pushValid,
  input  logic [IDX_W-1:0]         pushTask,
  input  logic [PC_W-1:0]          pushData,
  input  logic                     popValid,
  input  logic [IDX_W-1:0]         popTask,
  output logic [PC_W-1:0]          popData,
  input  logic                     restartValid,
  input  logic [IDX_W-1:0]         restartTask,
  input  logic [PC_W-1:0]          restartPc,
  input  logic                     markValid,
  input  logic [IDX_W-1:0]         markTask,
  input  logic [STATE_W-1:0]       markBits,
  input  logic                     loadValid,
  input  logic [IDX_W-1:0]         loadTask,
  input  logic [SNAP_W-1:0]        loadWord,
  input  logic [IDX_W-1:0]         snapTask,
  output logic [SNAP_W-1:0]        snapWord,
  output logic [TASKS*PC_W-1:0]    taskPc,
  output logic [TASKS*STATE_W-1:0] taskState
);
  laneCmd_t [TASKS-1:0] cmd;

  ctx_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .pushValid    (pushValid),
    .pushTask     (pushTask),
    .popValid     (popValid),
    .popTask      (popTask),
    .restartValid (restartValid),
    .restartTask  (restartTask),
    .markValid    (markValid),
    .markTask     (markTask),
    .loadValid    (loadValid),
    .loadTask     (loadTask),
    .cmd          (cmd)
  );

  ctx_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .pushData  (pushData),
    .restartPc (restartPc),
    .markBits  (markBits),
    .loadWord  (loadWord),
    .popTask   (popTask),
    .snapTask  (snapTask),
    .popData   (popData),
    .snapWord  (snapWord),
    .taskPc    (taskPc),
    .taskState (taskState)
  );
endmodule

// File: tb/task_ctx_bank_tb.sv
`timescale 1ns/1ps
module task_ctx_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushValid = 0, popValid = 0, restartValid = 0, markValid = 0, loadValid = 0;
  logic [1:0]  pushTask = 0, popTask = 0, restartTask = 0, markTask = 0, loadTask = 0, snapTask = 0;
  logic [15:0] pushData = 0, restartPc = 0;
  logic [3:0]  markBits = 0;
  logic [86:0] loadWord = '0;
  logic [15:0] popData;
  logic [86:0] snapWord;
  logic [63:0] taskPc;
  logic [15:0] taskState;

  int checks = 0;
  int errors = 0;
  logic [15:0] expQ [$];
  string       tagQ [$];

  always #10 clk = ~clk;

  task_ctx_bank u_dut (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .pushTask(pushTask), .pushData(pushData),
    .popValid(popValid), .popTask(popTask), .popData(popData),
    .restartValid(restartValid), .restartTask(restartTask), .restartPc(restartPc),
    .markValid(markValid), .markTask(markTask), .markBits(markBits),
    .loadValid(loadValid), .loadTask(loadTask), .loadWord(loadWord),
    .snapTask(snapTask), .snapWord(snapWord),
    .taskPc(taskPc), .taskState(taskState)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // start a new cycle with all requests idle
  task automatic beginCycle();
    @(posedge clk);
    #1;
    pushValid = 0; popValid = 0; restartValid = 0; markValid = 0; loadValid = 0;
  endtask

  // commit the current requests and wait to the middle of the next cycle
  task automatic settle();
    beginCycle();
    @(negedge clk);
  endtask

  // driver: queue the expected pop result and raise the pop request
  task automatic expectPop(input logic [1:0] t, input logic [15:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
    popValid = 1; popTask = t;
  endtask

  task automatic push(input logic [1:0] t, input logic [15:0] v);
    pushValid = 1; pushTask = t; pushData = v;
  endtask

  function automatic logic [15:0] pcOf(input int t);
    return taskPc[t*16 +: 16];
  endfunction

  function automatic logic [3:0] stOf(input int t);
    return taskState[t*4 +: 4];
  endfunction

  // monitor: compare each pop result against the scoreboard
  always @(negedge clk) begin
    if (rstN && popValid) begin
      if (expQ.size() == 0) begin
        check("R3 unexpected pop", 128'(popData), 128'hDEAD);
      end else begin
        logic [15:0] e;
        string tg;
        e  = expQ.pop_front();
        tg = tagQ.pop_front();
        check(tg, 128'(popData), 128'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 pcs", 128'(taskPc), 128'h0);
    check("R1 state", 128'(taskState), 128'h0);
    check("R1 snap", 128'(snapWord), 128'h0);
    beginCycle(); expectPop(2, 16'h0, "R1 empty pop");

    // R2 newest-first order, per-task isolation
    beginCycle(); push(1, 16'h1111);
    beginCycle(); push(1, 16'h2222);
    beginCycle(); push(1, 16'h3333);
    beginCycle(); push(3, 16'hAAAA);
    beginCycle(); expectPop(1, 16'h3333, "R2 pop1");
    beginCycle(); expectPop(1, 16'h2222, "R2 pop2");
    beginCycle(); expectPop(1, 16'h1111, "R2 pop3");
    // R10 push and pop to different tasks together
    beginCycle(); push(0, 16'h5555); expectPop(3, 16'hAAAA, "R10 pop side");
    beginCycle(); expectPop(0, 16'h5555, "R10 push side");

    // R3 empty pops
    beginCycle(); expectPop(1, 16'h0, "R3 empty a");
    beginCycle(); expectPop(1, 16'h0, "R3 empty b");
    beginCycle(); push(1, 16'h7777);
    beginCycle(); expectPop(1, 16'h7777, "R3 after empty");
    beginCycle(); expectPop(1, 16'h0, "R3 empty again");

    // R4 overflow drops the oldest
    for (int k = 1; k <= 5; k++) begin
      beginCycle(); push(2, 16'(k * 16'h0101));
    end
    beginCycle(); expectPop(2, 16'h0505, "R4 pop1");
    beginCycle(); expectPop(2, 16'h0404, "R4 pop2");
    beginCycle(); expectPop(2, 16'h0303, "R4 pop3");
    beginCycle(); expectPop(2, 16'h0202, "R4 pop4");
    beginCycle(); expectPop(2, 16'h0000, "R4 pop5");

    // R7 marks accumulate
    beginCycle(); markValid = 1; markTask = 0; markBits = 4'b1011;
    beginCycle(); markValid = 1; markTask = 0; markBits = 4'b0100;
    beginCycle(); push(0, 16'h0ABC);
    settle();
    check("R7 or", 128'(stOf(0)), 128'hF);

    // R5 restart
    beginCycle(); restartValid = 1; restartTask = 0; restartPc = 16'h1234;
    settle();
    check("R5 pc", 128'(pcOf(0)), 128'h1234);
    check("R5 state", 128'(stOf(0)), 128'h0);
    check("R6 other pcs", 128'(taskPc[63:16]), 128'h0);
    beginCycle(); expectPop(0, 16'h0ABC, "R6 stack kept");

    // R7 restart beats mark
    beginCycle(); markValid = 1; markTask = 1; markBits = 4'b0101;
    settle();
    check("R7 mark", 128'(stOf(1)), 128'h5);
    beginCycle(); markValid = 1; markTask = 1; markBits = 4'b1010;
    restartValid = 1; restartTask = 1; restartPc = 16'h0042;
    settle();
    check("R7 restart wins", 128'(stOf(1)), 128'h0);
    check("R5 pc task1", 128'(pcOf(1)), 128'h0042);

    // R8 snapshot layout
    beginCycle(); restartValid = 1; restartTask = 3; restartPc = 16'h00C3;
    beginCycle(); markValid = 1; markTask = 3; markBits = 4'b0010;
    beginCycle(); push(3, 16'h0D01);
    beginCycle(); push(3, 16'h0D02);
    settle();
    snapTask = 3;
    #1;
    check("R8 snap", 128'(snapWord),
          128'({16'h0, 16'h0, 16'h0D01, 16'h0D02, 3'd2, 4'b0010, 16'h00C3}));

    // R9 restore with clean word
    beginCycle(); loadValid = 1; loadTask = 3; loadWord = 87'h0400;
    settle();
    check("R9 pc", 128'(pcOf(3)), 128'h0400);
    check("R9 state", 128'(stOf(3)), 128'h0);
    beginCycle(); expectPop(3, 16'h0, "R9 empty");

    // R9 restore with content
    beginCycle(); loadValid = 1; loadTask = 2;
    loadWord = (87'h0BEE << 23) | (87'd1 << 20) | (87'h8 << 16) | 87'h0222;
    settle();
    check("R9 pc2", 128'(pcOf(2)), 128'h0222);
    check("R9 state2", 128'(stOf(2)), 128'h8);
    snapTask = 2;
    #1;
    check("R8 snap2", 128'(snapWord),
          128'((87'h0BEE << 23) | (87'd1 << 20) | (87'h8 << 16) | 87'h0222));
    beginCycle(); expectPop(2, 16'h0BEE, "R9 entry");
    beginCycle(); expectPop(2, 16'h0, "R9 drained");

    settle();
    check("R2 scoreboard drained", 128'(expQ.size()), 128'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule